// File: doc/BRIEF.md
# Eight-Bit Compare Timer with Waveform Outputs

This block is an eight-bit counter that advances on each cycle where a clock-enable input is high. Two compare channels watch the count and drive one output pin each. A three-bit mode field picks the count sequence:

- free-running up count;
- clear-on-compare, with the wrap point taken from channel A;
- single-slope PWM;
- dual-slope (up then down) PWM.

The end of the sequence (TOP) is either the all-ones value or channel A's compare value.

In the PWM modes, a write to a compare register lands in a shadow copy. The shadow copy reaches the live comparator only at the end of a period, so a pulse is never cut short or stretched. In the non-PWM modes, writes take effect at once. A force strobe applies a channel's pin action without a real match.

Overflow and compare events latch sticky flags. Software clears a flag by writing a one to its bit. Software configures and observes everything through a small synchronous register port with a one-cycle registered read.

Top module: `tmr8_pwm`

## Requirements
- R1: Synchronous active-high reset sets mode 0, both output modes 0, counter 0, both compare and shadow values 0, all flags 0, both pins low and rdata 0.
- R2: Mode 0 (free-running) works as follows:
  - each cycle with `tick` high adds one to the count, wrapping from 0xFF to 0x00;
  - that wrap sets the overflow flag;
  - with `tick` low the count holds, and stays readable and writable.
- R3: Mode 2 (clear-on-compare) counts up to channel A's value, then returns to 0 on the next tick. The overflow flag is set only when the count wraps from 0xFF.
- R4: When the count equals a channel's active compare value, that channel's flag is set by the next tick, not before.
- R5: Writing address 4 clears each flag whose bit is one: bit 0 overflow, bit 1 channel A, bit 2 channel B. Zero bits leave flags unchanged. A flag set in the same cycle as its clear wins.
- R6: A write to the counter (address 1) in a cycle where `tick` is high loads the written value. That tick is then discarded: no count step, no flag and no pin action.
- R7: Compare register writes behave as follows:
  - in PWM modes (1, 3, 5, 7), a write to address 2 (A) or 3 (B) goes to the shadow value;
  - the shadow value is copied to the active value on the tick that leaves TOP;
  - in other modes, the write sets both the shadow and active values at once;
  - reads of addresses 2 and 3 return the shadow value.
- R8: Fast PWM runs in modes 3 (TOP 0xFF) and 7 (TOP = A):
  - the count runs 0..TOP and wraps;
  - the wrap sets the overflow flag;
  - with output mode 2, the pin goes high at the wrap and low on a match;
  - output mode 3 gives the inverse.
- R9: Phase-correct PWM runs in modes 1 (TOP 0xFF) and 5 (TOP = A):
  - the count goes up to TOP, then down to 0, without repeating either end value;
  - the overflow flag is set on the tick that leaves 0 while counting down;
  - with output mode 2, the pin clears on an up-count match and sets on a down-count match;
  - output mode 3 gives the inverse.
- R10: In non-PWM modes, a match applies the channel's output mode to its pin: 0 none, 1 toggle, 2 clear, 3 set. Output mode 0 never changes the pin in any mode.
- R11: Writing address 5 bit 0 (A) or bit 1 (B) in a non-PWM mode applies that channel's output mode to its pin, sets no flag and leaves the count unchanged. In PWM modes the strobe has no effect. Address 5 reads as zero.
- R12: Address 0 holds the mode in bits 2:0, channel A's output mode in bits 4:3 and channel B's in bits 6:5. Address 1 is the counter. rdata shows the register selected by `addr` one clock later. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable; one counter step per cycle it is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (3) | Register address for write and read |
| wdata | input | W (8) | Write data |
| rdata | output | W (8) | Registered read data for `addr` |
| out_a | output | 1 | Channel A waveform pin |
| out_b | output | 1 | Channel B waveform pin |
| irq_ovf | output | 1 | Sticky overflow flag |
| irq_cmp_a | output | 1 | Sticky channel A compare flag |
| irq_cmp_b | output | 1 | Sticky channel B compare flag |

## Verification
The count sequence is driven in the free-running, clear-on-compare, single-slope and dual-slope modes. Stepping near the wrap and turn points separates an off-by-one TOP or BOTTOM from a correct one, and separates a flag that fires on reaching a value from one that fires on leaving it.

In single-slope PWM, a new channel A value is written mid-period and then run across both the old and new match points. This tells a shadowed write from one that takes effect at once.

A counter write landing on a tick, and force strobes issued in both a non-PWM and a PWM mode, show which source wins and which strobes are ignored. These are judged from the read port and the pins alone.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef struct packed {
    logic pwm;    // any PWM mode: compare writes are shadowed
    logic pc;     // dual-slope count
    logic fast;   // single-slope PWM
    logic ctc;    // clear on channel A compare
    logic top_a;  // TOP comes from channel A
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [2:0] m);
    mode_dec_t d;
    d = '0;
    case (m)
      3'd1: begin d.pwm = 1'b1; d.pc = 1'b1; end
      3'd2: begin d.ctc = 1'b1; d.top_a = 1'b1; end
      3'd3: begin d.pwm = 1'b1; d.fast = 1'b1; end
      3'd5: begin d.pwm = 1'b1; d.pc = 1'b1; d.top_a = 1'b1; end
      3'd7: begin d.pwm = 1'b1; d.fast = 1'b1; d.top_a = 1'b1; end
      default: ;  // 0, 4, 6: free-running
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tmr8_count.sv
module tmr8_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         m_pc,
  input  logic         m_fast,
  input  logic         m_ctc,
  input  logic         m_top_a,
  input  logic [W-1:0] top_a_val,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         at_top,
  output logic         ovf_evt
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] BOTV = '0;

  logic [W-1:0] top_v;
  logic [W-1:0] nxt;
  logic         nxt_up;

  assign top_v  = m_top_a ? top_a_val : MAXV;
  assign at_top = (cnt == top_v);

  always_comb begin
    nxt    = cnt + 1'b1;
    nxt_up = up;
    if (m_pc) begin
      if (up) begin
        if (at_top) begin
          nxt_up = 1'b0;
          nxt    = cnt - 1'b1;
        end
      end else if (cnt == BOTV) begin
        nxt_up = 1'b1;
      end else begin
        nxt = cnt - 1'b1;
      end
    end else begin
      nxt_up = 1'b1;
      if ((m_ctc || m_fast) && at_top) nxt = BOTV;
    end
  end

  assign ovf_evt = step & (m_pc   ? (!up && cnt == BOTV) :
                           m_fast ? at_top : (cnt == MAXV));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= BOTV;
      up  <= 1'b1;
    end else if (cnt_wr) begin
      cnt <= cnt_wdata;
    end else if (step) begin
      cnt <= nxt;
      up  <= nxt_up;
    end else if (!m_pc) begin
      up  <= 1'b1;
    end
  end

  // R2: wrap from MAX in free-running count
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !m_pc && !m_fast && !m_ctc && cnt == MAXV) |=> (cnt == BOTV));
  // R2: no tick and no write keeps the count
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !cnt_wr) |=> $stable(cnt));
  // R6: a counter write always lands
  a_r6_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(cnt_wdata)));
  // R8: single-slope wraps to zero after TOP
  a_r8_fast_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && m_fast && at_top) |=> (cnt == BOTV));
  // R9: dual-slope turns down at TOP
  a_r9_turn_down: assert property (@(posedge clk) disable iff (rst)
    (step && m_pc && up && at_top) |=> !up);
endmodule

// File: rtl/tmr8_ochan.sv
module tmr8_ochan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         m_pwm,
  input  logic         m_fast,
  input  logic [1:0]   com,
  input  logic [W-1:0] cnt,
  input  logic         up,
  input  logic         at_top,
  input  logic         buf_wr,
  input  logic [W-1:0] wdata,
  input  logic         force_cmp,
  input  logic         flag_clr,
  output logic [W-1:0] act,
  output logic [W-1:0] bufv,
  output logic         pin,
  output logic         flag
);
  logic hit;
  logic pin_nxt;

  assign hit = step & (cnt == act);

  always_comb begin
    pin_nxt = pin;
    if (!m_pwm) begin
      if (hit || force_cmp) begin
        case (com)
          2'd1:    pin_nxt = ~pin;
          2'd2:    pin_nxt = 1'b0;
          2'd3:    pin_nxt = 1'b1;
          default: pin_nxt = pin;
        endcase
      end
    end else if (m_fast) begin
      if (com[1]) begin
        if (hit)           pin_nxt = com[0];
        if (step && at_top) pin_nxt = ~com[0];  // wrap wins over match
      end
    end else begin
      if (com[1] && hit) pin_nxt = up ? com[0] : ~com[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= '0;
      bufv <= '0;
      pin  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (buf_wr) begin
        bufv <= wdata;
        if (!m_pwm) act <= wdata;
      end
      if (m_pwm && step && at_top) act <= bufv;
      flag <= (flag & ~flag_clr) | hit;
      pin  <= pin_nxt;
    end
  end

  // R4: a match seen on a tick leaves the flag set
  a_r4_flag_set: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == act) |=> flag);
  // R11: without a tick the flag cannot rise (force sets none)
  a_r11_no_flag_rise: assert property (@(posedge clk) disable iff (rst)
    (!step && !flag) |=> !flag);
  // R7: in PWM modes the live value moves only at TOP
  a_r7_shadow_held: assert property (@(posedge clk) disable iff (rst)
    (m_pwm && !(step && at_top)) |=> $stable(act));
  // R10: output mode 0 leaves the pin alone
  a_r10_none_holds: assert property (@(posedge clk) disable iff (rst)
    (com == 2'd0) |=> $stable(pin));
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          out_a,
  output logic          out_b,
  output logic          irq_ovf,
  output logic          irq_cmp_a,
  output logic          irq_cmp_b
);
  import tmr8_pkg::*;

  localparam int NCH = 2;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CNT  = AW'(1);
  localparam int            A_CMP0 = 2;
  localparam logic [AW-1:0] A_FLG  = AW'(A_CMP0 + NCH);
  localparam logic [AW-1:0] A_FRC  = AW'(A_CMP0 + NCH + 1);

  logic [2:0]   mode_q;
  logic [1:0]   com_q [NCH];
  logic         ovf_q;
  mode_dec_t    md;
  logic         cnt_wr, step, flag_wr, frc_wr;
  logic [W-1:0] cnt;
  logic         up, at_top, ovf_evt;
  logic [W-1:0] act  [NCH];
  logic [W-1:0] bufv [NCH];
  logic         pin  [NCH];
  logic         flag [NCH];
  logic [W-1:0] rd_v;

  assign md      = decode_mode(mode_q);
  assign cnt_wr  = wr_en && (addr == A_CNT);
  assign flag_wr = wr_en && (addr == A_FLG);
  assign frc_wr  = wr_en && (addr == A_FRC);
  assign step    = tick && !cnt_wr;

  tmr8_count #(.W(W)) u_count (
    .clk(clk), .rst(rst), .step(step),
    .m_pc(md.pc), .m_fast(md.fast), .m_ctc(md.ctc), .m_top_a(md.top_a),
    .top_a_val(act[0]), .cnt_wr(cnt_wr), .cnt_wdata(wdata),
    .cnt(cnt), .up(up), .at_top(at_top), .ovf_evt(ovf_evt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr8_ochan #(.W(W)) u_ch (
      .clk(clk), .rst(rst), .step(step),
      .m_pwm(md.pwm), .m_fast(md.fast), .com(com_q[i]),
      .cnt(cnt), .up(up), .at_top(at_top),
      .buf_wr(wr_en && (addr == AW'(A_CMP0 + i))), .wdata(wdata),
      .force_cmp(frc_wr && wdata[i]), .flag_clr(flag_wr && wdata[1+i]),
      .act(act[i]), .bufv(bufv[i]), .pin(pin[i]), .flag(flag[i])
    );
  end

  always_comb begin
    rd_v = '0;
    case (addr)
      A_CTRL: begin
        rd_v[2:0] = mode_q;
        for (int i = 0; i < NCH; i++) rd_v[3+2*i +: 2] = com_q[i];
      end
      A_CNT: rd_v = cnt;
      A_FLG: begin
        rd_v[0] = ovf_q;
        for (int i = 0; i < NCH; i++) rd_v[1+i] = flag[i];
      end
      default: begin
        for (int i = 0; i < NCH; i++)
          if (addr == AW'(A_CMP0 + i)) rd_v = bufv[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      for (int i = 0; i < NCH; i++) com_q[i] <= '0;
      ovf_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) begin
        mode_q <= wdata[2:0];
        for (int i = 0; i < NCH; i++) com_q[i] <= wdata[3+2*i +: 2];
      end
      ovf_q <= (ovf_q & ~(flag_wr & wdata[0])) | ovf_evt;
      rdata <= rd_v;
    end
  end

  assign out_a     = pin[0];
  assign out_b     = pin[1];
  assign irq_ovf   = ovf_q;
  assign irq_cmp_a = flag[0];
  assign irq_cmp_b = flag[1];

  // R1: reset leaves every output quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (rdata == '0 && !out_a && !out_b && !irq_ovf && !irq_cmp_a && !irq_cmp_b));
  // R5: write-one clears the overflow flag unless it is set again
  a_r5_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && wdata[0] && !ovf_evt) |=> !irq_ovf);
  // R6: a tick colliding with a counter write raises no overflow
  a_r6_tick_dropped: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !irq_ovf) |=> !irq_ovf);
endmodule

// File: tb/tmr8_pwm_bench.sv
module tmr8_pwm_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       out_a, out_b, irq_ovf, irq_cmp_a, irq_cmp_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  tmr8_pwm u_tmr8_pwm (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .out_a(out_a), .out_b(out_b),
    .irq_ovf(irq_ovf), .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 R12 register after reset", v, 0);
    end
    chk("R1 pins low", {out_a, out_b}, 0);
    chk("R1 flags clear", {irq_ovf, irq_cmp_a, irq_cmp_b}, 0);
  endtask

  task automatic t_normal();
    logic [7:0] v;
    wr(3'd1, 8'd253);
    run(2);
    rd(3'd1, v);
    chk("R2 count to MAX", v, 8'd255);
    chk("R2 no overflow before wrap", irq_ovf, 0);
    run(1);
    rd(3'd1, v);
    chk("R2 wrap to zero", v, 0);
    chk("R2 overflow on wrap", irq_ovf, 1);
    run(2);
    repeat (5) @(negedge clk);
    rd(3'd1, v);
    chk("R2 hold without tick", v, 8'd2);
    wr(3'd4, 8'h00);
    chk("R5 zero bit keeps flag", irq_ovf, 1);
    wr(3'd4, 8'h01);
    chk("R5 write one clears", irq_ovf, 0);
  endtask

  task automatic t_ctc();
    logic [7:0] v;
    wr(3'd0, 8'h0A);          // mode 2, A toggles
    wr(3'd2, 8'd4);
    wr(3'd3, 8'd2);
    wr(3'd1, 8'd0);
    wr(3'd4, 8'h07);
    run(2);
    chk("R4 no flag on reaching value", irq_cmp_b, 0);
    run(1);
    chk("R4 flag on next tick", irq_cmp_b, 1);
    run(2);
    rd(3'd1, v);
    chk("R3 clear after A", v, 0);
    chk("R3 compare A flag", irq_cmp_a, 1);
    chk("R10 toggle high", out_a, 1);
    chk("R3 no overflow", irq_ovf, 0);
    run(5);
    chk("R10 toggle low", out_a, 0);
    rd(3'd2, v);
    chk("R7 direct write readback", v, 8'd4);
  endtask

  task automatic t_write_priority();
    logic [7:0] v;
    wr(3'd0, 8'h00);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 3'd1; wdata = 8'd100;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3'd1, v);
    chk("R6 write beats tick", v, 8'd100);
    run(1);
    rd(3'd1, v);
    chk("R6 count resumes", v, 8'd101);
  endtask

  task automatic t_force();
    logic [7:0] v;
    wr(3'd0, 8'h18);          // mode 0, A set
    wr(3'd4, 8'h07);
    wr(3'd5, 8'h01);
    chk("R11 force sets pin", out_a, 1);
    chk("R11 force sets no flag", irq_cmp_a, 0);
    rd(3'd1, v);
    chk("R11 count untouched", v, 8'd101);
    wr(3'd0, 8'h10);          // mode 0, A clear
    wr(3'd5, 8'h01);
    chk("R10 clear action", out_a, 0);
    wr(3'd0, 8'h1B);          // fast PWM, A mode 3
    wr(3'd5, 8'h01);
    chk("R11 ignored in PWM", out_a, 0);
    rd(3'd5, v);
    chk("R11 force reads zero", v, 0);
  endtask

  task automatic t_fast_pwm();
    logic [7:0] v;
    wr(3'd0, 8'h13);          // mode 3, A mode 2
    wr(3'd1, 8'd10);
    wr(3'd4, 8'h07);
    wr(3'd2, 8'd50);
    rd(3'd2, v);
    chk("R7 shadow readback", v, 8'd50);
    run(50);
    chk("R7 new value not live yet", irq_cmp_a, 0);
    run(196);
    rd(3'd1, v);
    chk("R8 wrap to zero", v, 0);
    chk("R8 overflow at TOP", irq_ovf, 1);
    chk("R8 pin high at wrap", out_a, 1);
    run(50);
    chk("R8 pin high before match", out_a, 1);
    run(1);
    chk("R7 new value live after TOP", irq_cmp_a, 1);
    chk("R8 pin low on match", out_a, 0);
  endtask

  task automatic t_phase();
    logic [7:0] v;
    wr(3'd0, 8'h60);          // mode 0, B set
    wr(3'd5, 8'h02);
    chk("R11 force B", out_b, 1);
    wr(3'd2, 8'd3);
    wr(3'd3, 8'd1);
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h45);          // mode 5, B mode 2
    wr(3'd4, 8'h07);
    run(2);
    rd(3'd1, v);
    chk("R9 up count", v, 8'd2);
    chk("R9 clear on up match", out_b, 0);
    run(2);
    rd(3'd1, v);
    chk("R9 turned at TOP", v, 8'd2);
    run(2);
    rd(3'd1, v);
    chk("R9 down to zero", v, 0);
    chk("R9 set on down match", out_b, 1);
    chk("R9 no overflow yet", irq_ovf, 0);
    run(1);
    rd(3'd1, v);
    chk("R9 turned at BOTTOM", v, 8'd1);
    chk("R9 overflow at BOTTOM", irq_ovf, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_normal();
    t_ctc();
    t_write_priority();
    t_force();
    t_fast_pwm();
    t_phase();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule